// File: doc/BRIEF.md
# Fault Isolation Register Cluster

This block gathers error pulses from three neighbouring logic regions into three fault isolation units. Each unit holds a sticky 64-bit fault register, a mask register and two action registers. Every unmasked fault bit is routed by the two action bits that share its position to exactly one of four outcomes: system checkstop, recoverable, unit checkstop or local. Each outcome drives one attention output per unit.

Software reaches all state through a small addressed register bus. Units sit at a stride of 0x40, so the unit index is `bus_addr[7:6]` and the register offset is `bus_addr[5:0]`. Two alias addresses act in bulk. An AND alias clears fault bits and an OR alias sets mask bits, so one write handles many bits without a read-modify-write. Index 3 (addresses 0xC0 to 0xC3) holds a summary that shows which unit raises each attention class.

Top module: `fir_cluster`

## Requirements
- R1: Reset clears every fault register and both action registers, sets every mask register to all ones, and clears all attention outputs.
- R2: A fault bit set by `err_in` (unit u uses bits `[u*64 +: 64]`) stays set until software clears it.
- R3: A write to offset 1 replaces the fault register with its current value ANDed with the write data.
- R4: Writes to offsets 0, 3, 6 and 7 load the fault, mask, action0 and action1 registers. Reads at 0 and 1 return the fault register, reads at 3 and 5 return the mask, and reads at 6 and 7 return action0 and action1. Writes to any other offset change nothing, and reads there return zero.
- R5: A write to offset 5 ORs the write data into the mask register.
- R6: When an error input and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: A fault bit that is set, unmasked, clear in action0 and clear in action1 drives `chkstop_o`.
- R8: A fault bit that is set, unmasked, clear in action0 and set in action1 drives `recov_o`.
- R9: A fault bit that is set, unmasked, set in action0 and set in action1 drives `unitcs_o`.
- R10: A fault bit that is set, unmasked, set in action0 and clear in action1 drives only `local_o`.
- R11: Masked fault bits drive no attention output.
- R12: Each attention output is registered. It changes one clock edge after the fault, mask or action state that causes it.
- R13: Reads at 0xC0, 0xC1, 0xC2 and 0xC3 return, in bits [2:0], the checkstop, recoverable, unit checkstop and local outputs. Bit u of each belongs to the unit at base u*0x40.
- R14: Fault bit 63 is set when the stored parity of a mask or action register disagrees with its contents. Ordinary bus writes to those registers never set it. An error input on bit 63 also sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| err_in | input | 192 | Error inputs, 64 per unit |
| bus_valid | input | 1 | Bus access strobe |
| bus_write | input | 1 | Write when high together with bus_valid |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational from bus_addr |
| chkstop_o | output | 3 | System checkstop attention per unit |
| recov_o | output | 3 | Recoverable attention per unit |
| unitcs_o | output | 3 | Unit checkstop attention per unit |
| local_o | output | 3 | Local-only attention per unit |

## Verification
The four action codes are each applied to a single isolated fault bit. This shows that every code reaches its own output and no other. The same bit is then masked, so masking can be told apart from a wrong class. A clear and an error on the same bit in one cycle separates set priority from clear priority. Using the upper units and the summary addresses exposes any mistake in stride decode. Random writes to every offset, mixed with sparse random errors, are compared each cycle against a bench model. This catches alias mixups, in which an AND alias behaves as a plain load or an OR alias as a replace.

// File: rtl/fir_cluster.sv
module fir_cluster #(
  parameter int NUM_UNITS   = 3,
  parameter int DATA_W      = 64,
  parameter int ADDR_W      = 8,
  parameter int STRIDE_LOG2 = 6
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_UNITS*DATA_W-1:0] err_in,
  input  logic                        bus_valid,
  input  logic                        bus_write,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [DATA_W-1:0]           bus_wdata,
  output logic [DATA_W-1:0]           bus_rdata,
  output logic [NUM_UNITS-1:0]        chkstop_o,
  output logic [NUM_UNITS-1:0]        recov_o,
  output logic [NUM_UNITS-1:0]        unitcs_o,
  output logic [NUM_UNITS-1:0]        local_o
);
  localparam int UNIT_W = ADDR_W - STRIDE_LOG2;
  localparam logic [UNIT_W-1:0] SUM_UNIT = UNIT_W'(NUM_UNITS);
  localparam logic [DATA_W-1:0] ONES = '1;
  localparam logic [STRIDE_LOG2-1:0] OFF_FLT  = STRIDE_LOG2'(0);
  localparam logic [STRIDE_LOG2-1:0] OFF_AND  = STRIDE_LOG2'(1);
  localparam logic [STRIDE_LOG2-1:0] OFF_MSK  = STRIDE_LOG2'(3);
  localparam logic [STRIDE_LOG2-1:0] OFF_OR   = STRIDE_LOG2'(5);
  localparam logic [STRIDE_LOG2-1:0] OFF_ACT0 = STRIDE_LOG2'(6);
  localparam logic [STRIDE_LOG2-1:0] OFF_ACT1 = STRIDE_LOG2'(7);

  wire                   wr       = bus_valid & bus_write;
  wire [UNIT_W-1:0]      sel_unit = bus_addr[ADDR_W-1:STRIDE_LOG2];
  wire [STRIDE_LOG2-1:0] sel_off  = bus_addr[STRIDE_LOG2-1:0];

  logic [DATA_W-1:0] fault_w [NUM_UNITS];
  logic [DATA_W-1:0] mask_w  [NUM_UNITS];
  logic [DATA_W-1:0] act0_w  [NUM_UNITS];
  logic [DATA_W-1:0] act1_w  [NUM_UNITS];

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    logic [DATA_W-1:0] fault_q, mask_q, act0_q, act1_q, fault_next, live;
    logic              mpar_q, a0par_q, a1par_q;

    wire hit     = wr && (sel_unit == UNIT_W'(u));
    wire par_err = (^mask_q != mpar_q) | (^act0_q != a0par_q) | (^act1_q != a1par_q);

    always_comb begin
      fault_next = fault_q;
      if (hit && sel_off == OFF_FLT)      fault_next = bus_wdata;
      else if (hit && sel_off == OFF_AND) fault_next = fault_q & bus_wdata;
      fault_next = fault_next | err_in[u*DATA_W +: DATA_W] | {par_err, {(DATA_W-1){1'b0}}};
    end

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fault_q <= '0;
        mask_q  <= ONES;
        act0_q  <= '0;
        act1_q  <= '0;
        mpar_q  <= ^ONES;
        a0par_q <= 1'b0;
        a1par_q <= 1'b0;
      end else begin
        fault_q <= fault_next;
        if (hit && sel_off == OFF_MSK) begin
          mask_q <= bus_wdata;
          mpar_q <= ^bus_wdata;
        end else if (hit && sel_off == OFF_OR) begin
          mask_q <= mask_q | bus_wdata;
          mpar_q <= ^(mask_q | bus_wdata);
        end
        if (hit && sel_off == OFF_ACT0) begin
          act0_q  <= bus_wdata;
          a0par_q <= ^bus_wdata;
        end
        if (hit && sel_off == OFF_ACT1) begin
          act1_q  <= bus_wdata;
          a1par_q <= ^bus_wdata;
        end
      end
    end

    assign live = fault_q & ~mask_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        chkstop_o[u] <= 1'b0;
        recov_o[u]   <= 1'b0;
        unitcs_o[u]  <= 1'b0;
        local_o[u]   <= 1'b0;
      end else begin
        chkstop_o[u] <= |(live & ~act0_q & ~act1_q);
        recov_o[u]   <= |(live & ~act0_q &  act1_q);
        unitcs_o[u]  <= |(live &  act0_q &  act1_q);
        local_o[u]   <= |(live &  act0_q & ~act1_q);
      end
    end

    assign fault_w[u] = fault_q;
    assign mask_w[u]  = mask_q;
    assign act0_w[u]  = act0_q;
    assign act1_w[u]  = act1_q;
  end

  always_comb begin
    bus_rdata = '0;
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (sel_unit == UNIT_W'(u)) begin
        case (sel_off)
          OFF_FLT, OFF_AND: bus_rdata = fault_w[u];
          OFF_MSK, OFF_OR:  bus_rdata = mask_w[u];
          OFF_ACT0:         bus_rdata = act0_w[u];
          OFF_ACT1:         bus_rdata = act1_w[u];
          default:          bus_rdata = '0;
        endcase
      end
    end
    if (sel_unit == SUM_UNIT) begin
      case (sel_off)
        STRIDE_LOG2'(0): bus_rdata = DATA_W'(chkstop_o);
        STRIDE_LOG2'(1): bus_rdata = DATA_W'(recov_o);
        STRIDE_LOG2'(2): bus_rdata = DATA_W'(unitcs_o);
        STRIDE_LOG2'(3): bus_rdata = DATA_W'(local_o);
        default:         bus_rdata = '0;
      endcase
    end
  end
endmodule

module fir_cluster_chk #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_valid,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] err_lo,
  input logic [DATA_W-1:0] fault0,
  input logic [DATA_W-1:0] mask0,
  input logic [DATA_W-1:0] act00,
  input logic [DATA_W-1:0] act10,
  input logic              chk0,
  input logic              rec0,
  input logic              loc0
);
  logic armed;
  always_ff @(posedge clk) armed <= rst_n;

  wire clr0 = bus_valid && bus_write && (bus_addr[ADDR_W-1:1] == '0);

  // R2
  sticky_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !$past(clr0)) |-> ((fault0 & $past(fault0)) == $past(fault0)));

  // R6
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> ((fault0 & $past(err_lo)) == $past(err_lo)));

  // R7
  chkstop_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (chk0 == $past(|(fault0 & ~mask0 & ~act00 & ~act10))));

  // R10
  local_late_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (loc0 == $past(|(fault0 & ~mask0 & act00 & ~act10))));

  // R11
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(&mask0)) |-> (!chk0 && !rec0 && !loc0));
endmodule

bind fir_cluster fir_cluster_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
  .bus_addr(bus_addr), .err_lo(err_in[DATA_W-1:0]), .fault0(fault_w[0]),
  .mask0(mask_w[0]), .act00(act0_w[0]), .act10(act1_w[0]),
  .chk0(chkstop_o[0]), .rec0(recov_o[0]), .loc0(local_o[0])
);

// File: tb/fir_cluster_bench.sv
module fir_cluster_bench;
  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [191:0] err_in = '0;
  logic         bus_valid = 1'b0;
  logic         bus_write = 1'b0;
  logic [7:0]   bus_addr = '0;
  logic [63:0]  bus_wdata = '0;
  logic [63:0]  bus_rdata;
  logic [2:0]   chkstop_o, recov_o, unitcs_o, local_o;

  int checks = 0;
  int errors = 0;

  logic [63:0] mf [3], mm [3], ma0 [3], ma1 [3];
  logic [2:0]  mcs, mrec, muc, mloc;

  always #(CLK_PERIOD/2) clk = ~clk;

  fir_cluster u_fir_cluster (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .chkstop_o(chkstop_o), .recov_o(recov_o),
    .unitcs_o(unitcs_o), .local_o(local_o)
  );

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(input logic [7:0] a);
    int u = int'(a[7:6]);
    if (u < 3) begin
      case (a[5:0])
        6'd0, 6'd1: return mf[u];
        6'd3, 6'd5: return mm[u];
        6'd6:       return ma0[u];
        6'd7:       return ma1[u];
        default:    return '0;
      endcase
    end
    case (a[5:0])
      6'd0:    return {61'd0, mcs};
      6'd1:    return {61'd0, mrec};
      6'd2:    return {61'd0, muc};
      6'd3:    return {61'd0, mloc};
      default: return '0;
    endcase
  endfunction

  task automatic model_edge(input logic wr, input logic [7:0] a, input logic [63:0] d,
                            input logic [191:0] e);
    for (int u = 0; u < 3; u++) begin
      logic [63:0] lv = mf[u] & ~mm[u];
      mcs[u]  = |(lv & ~ma0[u] & ~ma1[u]);
      mrec[u] = |(lv & ~ma0[u] &  ma1[u]);
      muc[u]  = |(lv &  ma0[u] &  ma1[u]);
      mloc[u] = |(lv &  ma0[u] & ~ma1[u]);
      if (wr && int'(a[7:6]) == u) begin
        case (a[5:0])
          6'd0: mf[u] = d;
          6'd1: mf[u] = mf[u] & d;
          6'd3: mm[u] = d;
          6'd5: mm[u] = mm[u] | d;
          6'd6: ma0[u] = d;
          6'd7: ma1[u] = d;
          default: ;
        endcase
      end
      mf[u] = mf[u] | e[u*64 +: 64];
    end
  endtask

  task automatic tick(input logic wr, input logic [7:0] a, input logic [63:0] d,
                      input logic [191:0] e);
    @(negedge clk);
    bus_valid = wr; bus_write = wr; bus_addr = a; bus_wdata = d; err_in = e;
    @(posedge clk);
    model_edge(wr, a, d, e);
    #1;
  endtask

  task automatic rd(input string tag, input logic [7:0] a);
    @(negedge clk);
    bus_valid = 1'b0; bus_write = 1'b0; bus_addr = a; err_in = '0;
    #1 chk(tag, bus_rdata, exp_read(a));
    @(posedge clk);
    model_edge(1'b0, a, '0, '0);
    #1;
  endtask

  task automatic chk_attn(input string tag);
    chk(tag, {52'd0, chkstop_o, recov_o, unitcs_o, local_o}, {52'd0, mcs, mrec, muc, mloc});
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog all-R actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int u = 0; u < 3; u++) begin
      mf[u] = '0; mm[u] = '1; ma0[u] = '0; ma1[u] = '0;
    end
    mcs = '0; mrec = '0; muc = '0; mloc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    #1;

    // R1 reset state
    chk_attn("R1 attention after reset");
    rd("R1 fault reset", 8'h00);
    rd("R1 mask reset", 8'h83);
    rd("R1 act0 reset", 8'h46);

    // R4 plain loads, unmapped offset
    tick(1, 8'h46, 64'hdead_beef_0123_4567, '0);
    rd("R4 act0 load unit1", 8'h46);
    tick(1, 8'h42, 64'hffff, '0);
    rd("R4 unmapped read zero", 8'h42);
    rd("R4 unmapped write ignored", 8'h40);
    tick(1, 8'h46, 64'h0, '0);

    // unit0 setup: unmask all, bit4 recov, bit8 unitcs, bit12 local
    tick(1, 8'h03, 64'h0, '0);
    tick(1, 8'h06, 64'h1100, '0);
    tick(1, 8'h07, 64'h0110, '0);
    rd("R4 act1 readback", 8'h07);

    // R7 / R12
    tick(0, 8'h00, '0, 192'h1);
    rd("R2 fault bit0 set", 8'h00);
    tick(0, 8'h00, '0, 192'h1);
    tick(0, 8'h00, '0, '0);
    chk("R7 checkstop raised", {63'd0, chkstop_o[0]}, 64'd1);
    chk_attn("R7 only checkstop");

    // R3 AND alias
    tick(1, 8'h01, ~64'h1, '0);
    chk("R12 attention holds one edge after clear", {63'd0, chkstop_o[0]}, 64'd1);
    rd("R3 and alias clears", 8'h01);
    chk("R12 attention drops", {63'd0, chkstop_o[0]}, 64'd0);

    tick(0, 8'h00, '0, 192'h10);
    chk("R12 not yet visible", {63'd0, recov_o[0]}, 64'd0);
    tick(0, 8'h00, '0, '0);
    chk_attn("R8 recoverable only");
    tick(1, 8'h01, '0, '0);

    tick(0, 8'h00, '0, 192'h100);
    tick(0, 8'h00, '0, '0);
    chk_attn("R9 unit checkstop only");
    tick(1, 8'h01, '0, '0);

    tick(0, 8'h00, '0, 192'h1000);
    tick(0, 8'h00, '0, '0);
    chk("R10 local raised", {63'd0, local_o[0]}, 64'd1);
    chk_attn("R10 local only");
    tick(1, 8'h01, '0, '0);
    tick(0, 8'h00, '0, '0);

    // R5 / R11
    tick(1, 8'h05, 64'h1, '0);
    rd("R5 or alias sets mask bit", 8'h03);
    tick(1, 8'h05, 64'h2, '0);
    rd("R5 or alias keeps prior bits", 8'h05);
    tick(0, 8'h00, '0, 192'h1);
    tick(0, 8'h00, '0, '0);
    chk("R11 masked bit quiet", {63'd0, chkstop_o[0]}, 64'd0);
    chk_attn("R11 attention model");

    // R6
    tick(1, 8'h01, 64'h0, 192'h10_0000);
    rd("R6 set beats clear", 8'h00);

    // R13 stride and summary
    tick(1, 8'h83, 64'h0, '0);
    tick(0, 8'h00, '0, {64'h8, 128'h0});
    tick(0, 8'h00, '0, '0);
    chk("R13 unit2 checkstop", {61'd0, chkstop_o}, exp_read(8'hC0));
    rd("R13 summary checkstop", 8'hC0);
    rd("R13 summary recov", 8'hC1);
    rd("R13 summary unitcs", 8'hC2);
    rd("R13 summary local", 8'hC3);

    // R14 parity bit
    for (int i = 0; i < 8; i++) begin
      tick(1, 8'h43, {$urandom, $urandom}, '0);
      tick(1, 8'h46, {$urandom, $urandom}, '0);
      tick(1, 8'h47, {$urandom, $urandom}, '0);
      tick(1, 8'h45, {$urandom, $urandom}, '0);
    end
    rd("R14 no spurious parity bit", 8'h40);
    tick(0, 8'h00, '0, {64'h0, 64'h8000_0000_0000_0000, 64'h0});
    rd("R14 error input bit63", 8'h40);

    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [7:0]   a;
      logic [191:0] e;
      int offs [7] = '{0, 1, 3, 5, 6, 7, 2};
      a = {2'($urandom_range(0, 2)), 6'(offs[$urandom_range(0, 6)])};
      e = '0;
      for (int u = 0; u < 3; u++)
        if ($urandom_range(0, 7) == 0) e[u*64 + $urandom_range(0, 63)] = 1'b1;
      if ($urandom_range(0, 1) == 0)
        tick(1, a, ($urandom_range(0, 1) != 0) ? {$urandom, $urandom} : ~(64'd1 << $urandom_range(0, 63)), e);
      else
        tick(0, a, '0, e);
      chk_attn("R12 random attention");
      if (n % 5 == 0) rd("R4 random readback", {2'($urandom_range(0, 3)), 6'($urandom_range(0, 7))});
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule